// File: doc/BRIEF.md
# Tagged SMBus Master Byte Queue with Interrupt Flags

This block is the byte staging queue between a processor's register interface and an SMBus master engine. In transmit direction the processor pushes bytes and the engine drains them. Each queued byte carries two control marks: an end-of-transfer mark and a repeated-start mark. The processor arms these marks in the control register before it pushes the byte. In receive direction the engine pushes incoming bytes and the processor drains them. Fill-level watermarks give an early low warning and an early high warning. The two watermark levels are always chosen together, from a small set of fixed pairs.

A four-flag event register records engine events. The events are a master status change, a received byte, an empty queue while transmitting, and a finished packet. An enable register masks each flag onto one processor interrupt line. A flag still latches while its enable bit is clear.

All byte paths are valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. A producer may hold valid for as long as it likes. The queue drops ready when it is full or when the path belongs to the other direction. Two cases are errors rather than normal back-pressure, and each sets a sticky bit. The first is a processor push while the queue is full. The second is a processor read request while the queue is empty.

Top module: `smb_tagq_top`

## Requirements
- R1: After reset, the event flags, the enable register and the control register all read 0x00, and the fill level is 0. The interrupt line and both error bits are 0.
- R2: Bytes leave the queue in the order they entered. The queue holds up to 8 entries, and each entry keeps its two marks with it.
- R3: Control register bit 7 is the end-of-transfer mark and bit 6 is the repeated-start mark. The next processor push stores both marks with its byte. Both bits clear once that push completes. The engine sees the stored marks on `eng_rd_stop` and `eng_rd_rstart`.
- R4: Control bits 5:4 select the watermark pair (low, high). 00 selects (2, 6), 01 selects (3, 5) and 10 selects (4, 4). `almost_empty` is high when fill ≤ low, and `almost_full` is high when fill ≥ high. Code 11 holds both watermarks low.
- R5: A processor push while full is ignored: the fill level and the stored contents are unchanged. It sets `err_ovf`, which stays set until a write of 1 to bit 0 at CSR address 3.
- R6: A processor read request while empty is ignored. It sets `err_udf`, which stays set until a write of 1 to bit 1 at CSR address 3.
- R7: Event bit 6 (received byte) sets in the cycle after the engine pushes a byte in receive direction.
- R8: Event bit 5 (transmit data request) sets in the cycle after a cycle in which `mst_tx_mode` is high and the queue is empty.
- R9: Event bit 4 sets the cycle after an `mst_pkt_done` pulse. Event bit 7 sets the cycle after an `mst_status_chg` pulse.
- R10: Writing 1 to an event bit at CSR address 0 clears it. If a set condition occurs in the same cycle as the clear, the bit stays set.
- R11: `irq` is the OR of the event bits ANDed with the enable bits at CSR address 1. A masked event still latches. Bits 3:0 of the event and enable registers read 0.
- R12: With `mst_rx_mode` high, the processor push path and the engine drain path are closed (ready/valid low). The engine push path and the processor read path are open. With `mst_rx_mode` low it is the other way round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | 0 event flags (write 1 to clear), 1 enables, 2 control, 3 error clear |
| csr_wdata | input | 8 | Register write data |
| irq_status | output | 8 | Event flag register |
| irq_enable | output | 8 | Enable register |
| fifo_ctrl | output | 8 | Control register: marks and watermark select |
| err_ovf | output | 1 | Sticky full-push error |
| err_udf | output | 1 | Sticky empty-read error |
| mst_rx_mode | input | 1 | Engine is receiving; selects queue direction |
| mst_tx_mode | input | 1 | Engine is transmitting |
| mst_status_chg | input | 1 | Pulse: engine status changed |
| mst_pkt_done | input | 1 | Pulse: packet finished |
| cpu_wr_valid | input | 1 | Processor push valid |
| cpu_wr_ready | output | 1 | Processor push ready |
| cpu_wr_data | input | 8 | Processor push byte |
| cpu_rd_valid | output | 1 | Processor read data valid |
| cpu_rd_ready | input | 1 | Processor read request |
| cpu_rd_data | output | 8 | Byte at queue head |
| eng_rd_valid | output | 1 | Engine drain valid |
| eng_rd_ready | input | 1 | Engine drain ready |
| eng_rd_data | output | 8 | Byte at queue head |
| eng_rd_stop | output | 1 | End-of-transfer mark of the head byte |
| eng_rd_rstart | output | 1 | Repeated-start mark of the head byte |
| eng_wr_valid | input | 1 | Engine push valid |
| eng_wr_ready | output | 1 | Engine push ready |
| eng_wr_data | input | 8 | Engine push byte |
| fill_level | output | 4 | Entries held |
| almost_empty | output | 1 | Low watermark reached |
| almost_full | output | 1 | High watermark reached |
| irq | output | 1 | Processor interrupt |

## Verification
The bench moves the fill level through every count from 0 to 8 under each watermark code. An off-by-one in a watermark comparison, or a pair taken from the wrong code, would show up as a flag at the wrong count.

It pushes into a full queue and then drains it. A design that overwrote the oldest entry or bumped the count would return the wrong eighth byte.

It clears the data-request flag while the queue stays empty. A design where the clear beats the set would drop a request that is still pending.

It arms the marks on single bytes among unmarked ones. A mark that stuck after its push, or one applied to the wrong byte, would show up at the engine side.

// File: rtl/smb_tagq_pkg.sv
package smb_tagq_pkg;
  localparam int BYTE_W  = 8;
  localparam int TAG_W   = 2;
  localparam int ENTRY_W = BYTE_W + TAG_W;
  localparam int NFLAG   = 4;

  typedef enum logic [1:0] {
    CSR_EVT  = 2'd0,
    CSR_EN   = 2'd1,
    CSR_CTRL = 2'd2,
    CSR_ERR  = 2'd3
  } csr_addr_e;

  typedef struct packed {
    logic              stop;
    logic              rstart;
    logic [BYTE_W-1:0] data;
  } entry_t;

  // Low watermark for a select code (code 3 unused by callers)
  function automatic int unsigned wm_low(input logic [1:0] sel);
    return 2 + int'(sel);
  endfunction

  // High watermark for a select code
  function automatic int unsigned wm_high(input logic [1:0] sel);
    return 6 - int'(sel);
  endfunction
endpackage

// File: rtl/smb_tagq_fifo.sv
module smb_tagq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 10,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          pop_i,
  output logic [W-1:0]  pop_data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign pop_data_o = mem[rd_ptr_q];
  assign count_o = count_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data_i;
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> (count_q == CW'(DEPTH)));

  // R6
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> (count_q == '0));
endmodule

// File: rtl/smb_tagq_level.sv
module smb_tagq_level
  import smb_tagq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [CW-1:0] count_i,
  input  logic [1:0]    sel_i,
  output logic          ae_o,
  output logic          af_o
);
  always_comb begin
    ae_o = 1'b0;
    af_o = 1'b0;
    if (sel_i != 2'b11) begin
      ae_o = int'(count_i) <= int'(wm_low(sel_i));
      af_o = int'(count_i) >= int'(wm_high(sel_i));
    end
  end
endmodule

// File: rtl/smb_tagq_irq.sv
module smb_tagq_irq #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic          en_we_i,
  input  logic [NF-1:0] en_data_i,
  output logic [NF-1:0] flags_o,
  output logic [NF-1:0] en_o,
  output logic          irq_o
);
  logic [NF-1:0] flags_q, en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      for (int k = 0; k < NF; k++) begin
        flags_q[k] <= set_i[k] | (flags_q[k] & ~clr_i[k]);
      end
      if (en_we_i) en_q <= en_data_i;
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign irq_o   = |(flags_q & en_q);

  for (genvar k = 0; k < NF; k++) begin : g_flag_chk
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> flags_o[k]);
  end

  // R11
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o == '0) |-> !irq_o);
endmodule

// File: rtl/smb_tagq_top.sv
module smb_tagq_top
  import smb_tagq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic [1:0]    csr_addr,
  input  logic [7:0]    csr_wdata,
  output logic [7:0]    irq_status,
  output logic [7:0]    irq_enable,
  output logic [7:0]    fifo_ctrl,
  output logic          err_ovf,
  output logic          err_udf,
  input  logic          mst_rx_mode,
  input  logic          mst_tx_mode,
  input  logic          mst_status_chg,
  input  logic          mst_pkt_done,
  input  logic          cpu_wr_valid,
  output logic          cpu_wr_ready,
  input  logic [7:0]    cpu_wr_data,
  output logic          cpu_rd_valid,
  input  logic          cpu_rd_ready,
  output logic [7:0]    cpu_rd_data,
  output logic          eng_rd_valid,
  input  logic          eng_rd_ready,
  output logic [7:0]    eng_rd_data,
  output logic          eng_rd_stop,
  output logic          eng_rd_rstart,
  input  logic          eng_wr_valid,
  output logic          eng_wr_ready,
  input  logic [7:0]    eng_wr_data,
  output logic [CW-1:0] fill_level,
  output logic          almost_empty,
  output logic          almost_full,
  output logic          irq
);
  logic       tx_dir, full, empty;
  logic       q_push, q_pop;
  entry_t     push_ent, head_ent;
  logic [CW-1:0] count;
  logic       mark_stop_q, mark_rs_q;
  logic [1:0] wm_sel_q;
  logic       ovf_q, udf_q;
  logic       cpu_push_fire, eng_push_fire;
  logic       ovf_evt, udf_evt;
  logic       wr_evt, wr_en, wr_ctrl, wr_err;
  logic [NFLAG-1:0] evt_set, evt_clr, evt_flags, evt_en;
  logic       unused_bits;

  assign unused_bits = ^csr_wdata[3:2];

  assign tx_dir = !mst_rx_mode;

  // Direction steering
  assign cpu_wr_ready = tx_dir && !full;
  assign eng_wr_ready = !tx_dir && !full;
  assign eng_rd_valid = tx_dir && !empty;
  assign cpu_rd_valid = !tx_dir && !empty;

  assign cpu_push_fire = cpu_wr_valid && cpu_wr_ready;
  assign eng_push_fire = eng_wr_valid && eng_wr_ready;

  always_comb begin
    if (tx_dir) begin
      q_push   = cpu_wr_valid;
      q_pop    = eng_rd_ready;
      push_ent = '{stop: mark_stop_q, rstart: mark_rs_q, data: cpu_wr_data};
    end else begin
      q_push   = eng_wr_valid;
      q_pop    = cpu_rd_ready;
      push_ent = '{stop: 1'b0, rstart: 1'b0, data: eng_wr_data};
    end
  end

  smb_tagq_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (q_push),
    .push_data_i (push_ent),
    .pop_i       (q_pop),
    .pop_data_o  (head_ent),
    .full_o      (full),
    .empty_o     (empty),
    .count_o     (count)
  );

  assign eng_rd_data   = head_ent.data;
  assign eng_rd_stop   = head_ent.stop;
  assign eng_rd_rstart = head_ent.rstart;
  assign cpu_rd_data   = head_ent.data;
  assign fill_level    = count;

  smb_tagq_level #(.CW(CW)) u_level (
    .count_i (count),
    .sel_i   (wm_sel_q),
    .ae_o    (almost_empty),
    .af_o    (almost_full)
  );

  // Register writes
  assign wr_evt  = csr_we && (csr_addr == CSR_EVT);
  assign wr_en   = csr_we && (csr_addr == CSR_EN);
  assign wr_ctrl = csr_we && (csr_addr == CSR_CTRL);
  assign wr_err  = csr_we && (csr_addr == CSR_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mark_stop_q <= 1'b0;
      mark_rs_q   <= 1'b0;
      wm_sel_q    <= 2'b00;
    end else if (wr_ctrl) begin
      mark_stop_q <= csr_wdata[7];
      mark_rs_q   <= csr_wdata[6];
      wm_sel_q    <= csr_wdata[5:4];
    end else if (cpu_push_fire) begin
      mark_stop_q <= 1'b0;
      mark_rs_q   <= 1'b0;
    end
  end

  assign fifo_ctrl = {mark_stop_q, mark_rs_q, wm_sel_q, 4'b0000};

  // Sticky errors
  assign ovf_evt = tx_dir && cpu_wr_valid && full;
  assign udf_evt = !tx_dir && cpu_rd_ready && empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_evt | (ovf_q & ~(wr_err & csr_wdata[0]));
      udf_q <= udf_evt | (udf_q & ~(wr_err & csr_wdata[1]));
    end
  end

  assign err_ovf = ovf_q;
  assign err_udf = udf_q;

  // Event flags: index 3..0 map to register bits 7..4
  assign evt_set = {mst_status_chg, eng_push_fire, mst_tx_mode && empty, mst_pkt_done};
  assign evt_clr = wr_evt ? csr_wdata[7:4] : '0;

  smb_tagq_irq #(.NF(NFLAG)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (evt_set),
    .clr_i     (evt_clr),
    .en_we_i   (wr_en),
    .en_data_i (csr_wdata[7:4]),
    .flags_o   (evt_flags),
    .en_o      (evt_en),
    .irq_o     (irq)
  );

  assign irq_status = {evt_flags, 4'b0000};
  assign irq_enable = {evt_en, 4'b0000};

  // R5
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_ovf) |-> $past(cpu_wr_valid && !mst_rx_mode && !cpu_wr_ready));

  // R12
  rx_cpu_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_rx_mode |-> (!cpu_wr_ready && !eng_rd_valid));

  // R4
  wm_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (almost_empty && almost_full) |-> (fifo_ctrl[5:4] == 2'b10 && fill_level == CW'(4)));

  // R3
  mark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_valid && cpu_wr_ready && !csr_we) |=> (fifo_ctrl[7:6] == 2'b00));
endmodule

// File: tb/smb_tagq_top_tb.sv
`timescale 1ns/1ps
module smb_tagq_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 0; logic [1:0] csr_addr = 0; logic [7:0] csr_wdata = 0;
  logic [7:0] irq_status, irq_enable, fifo_ctrl;
  logic err_ovf, err_udf;
  logic mst_rx_mode = 0, mst_tx_mode = 0, mst_status_chg = 0, mst_pkt_done = 0;
  logic cpu_wr_valid = 0; logic cpu_wr_ready; logic [7:0] cpu_wr_data = 0;
  logic cpu_rd_valid; logic cpu_rd_ready = 0; logic [7:0] cpu_rd_data;
  logic eng_rd_valid; logic eng_rd_ready = 0; logic [7:0] eng_rd_data;
  logic eng_rd_stop, eng_rd_rstart;
  logic eng_wr_valid = 0; logic eng_wr_ready; logic [7:0] eng_wr_data = 0;
  logic [3:0] fill_level;
  logic almost_empty, almost_full, irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smb_tagq_top dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [1:0] a, input logic [7:0] d);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 0; csr_wdata = 0;
  endtask

  task automatic cpu_push(input logic [7:0] d);
    cpu_wr_valid = 1; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr_valid = 0;
  endtask

  task automatic eng_pop(output logic [7:0] d, output logic s, output logic r);
    d = eng_rd_data; s = eng_rd_stop; r = eng_rd_rstart;
    eng_rd_ready = 1;
    @(negedge clk);
    eng_rd_ready = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", irq_status, 8'h00);
    chk("R1 enable", irq_enable, 8'h00);
    chk("R1 ctrl", fifo_ctrl, 8'h00);
    chk("R1 fill", fill_level, 0);
    chk("R1 irq/err", {irq, err_ovf, err_udf}, 3'b000);
  endtask

  task automatic t_order_tags();
    logic [7:0] d; logic s, r;
    logic [7:0] ed [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    logic es [4] = '{0, 0, 0, 1};
    logic er [4] = '{0, 1, 0, 0};
    cpu_push(8'h11);
    csr_wr(2, 8'h40);
    chk("R3 armed rstart", fifo_ctrl, 8'h40);
    cpu_push(8'h22);
    chk("R3 marks cleared", fifo_ctrl, 8'h00);
    cpu_push(8'h33);
    csr_wr(2, 8'h80);
    cpu_push(8'h44);
    chk("R2 fill 4", fill_level, 4);
    for (int i = 0; i < 4; i++) begin
      eng_pop(d, s, r);
      chk("R2 order", d, ed[i]);
      chk("R3 stop mark", s, es[i]);
      chk("R3 rstart mark", r, er[i]);
    end
    chk("R2 drained", fill_level, 0);
  endtask

  task automatic t_thresh();
    logic [7:0] d; logic s, r;
    for (int sel = 0; sel < 4; sel++) begin
      csr_wr(2, 8'(sel << 4));
      for (int n = 0; n <= 8; n++) begin
        chk("R4 almost_empty", almost_empty, (sel == 3) ? 0 : (n <= 2 + sel));
        chk("R4 almost_full", almost_full, (sel == 3) ? 0 : (n >= 6 - sel));
        if (n < 8) cpu_push(8'(n));
      end
      for (int i = 0; i < 8; i++) eng_pop(d, s, r);
    end
    csr_wr(2, 8'h00);
  endtask

  task automatic t_overflow();
    logic [7:0] d; logic s, r;
    for (int i = 0; i < 8; i++) cpu_push(8'h50 + 8'(i));
    chk("R5 ready low when full", cpu_wr_ready, 0);
    cpu_push(8'hEE);
    chk("R5 fill unchanged", fill_level, 8);
    chk("R5 err_ovf set", err_ovf, 1);
    for (int i = 0; i < 8; i++) begin
      eng_pop(d, s, r);
      chk("R5 contents intact", d, 8'h50 + 8'(i));
    end
    chk("R5 sticky", err_ovf, 1);
    csr_wr(3, 8'h01);
    chk("R5 cleared", err_ovf, 0);
  endtask

  task automatic t_rx();
    mst_rx_mode = 1;
    #1;
    chk("R12 cpu push closed", cpu_wr_ready, 0);
    chk("R12 engine push open", eng_wr_ready, 1);
    @(negedge clk);
    cpu_push(8'h99);
    chk("R12 cpu push ignored", {fill_level, err_ovf}, 5'b0);
    eng_wr_valid = 1; eng_wr_data = 8'hA5;
    @(negedge clk);
    eng_wr_valid = 0;
    chk("R7 data ready flag", irq_status, 8'h40);
    chk("R12 cpu read valid", cpu_rd_valid, 1);
    chk("R12 cpu read data", cpu_rd_data, 8'hA5);
    cpu_rd_ready = 1;
    @(negedge clk);
    cpu_rd_ready = 0;
    chk("R6 no error on good read", {fill_level, err_udf}, 5'b0);
    cpu_rd_ready = 1;
    @(negedge clk);
    cpu_rd_ready = 0;
    chk("R6 err_udf set", err_udf, 1);
    chk("R6 fill stays 0", fill_level, 0);
    csr_wr(3, 8'h02);
    chk("R6 cleared", err_udf, 0);
    csr_wr(0, 8'hF0);
    mst_rx_mode = 0;
    @(negedge clk);
    chk("R10 flags cleared", irq_status, 8'h00);
  endtask

  task automatic t_req();
    logic [7:0] d; logic s, r;
    mst_tx_mode = 1;
    @(negedge clk);
    chk("R8 request flag", irq_status, 8'h20);
    csr_wr(0, 8'h20);
    chk("R10 set wins over clear", irq_status, 8'h20);
    cpu_push(8'h01);
    csr_wr(0, 8'h20);
    chk("R10 clear when not empty", irq_status, 8'h00);
    mst_tx_mode = 0;
    eng_pop(d, s, r);
    chk("R8 byte out", d, 8'h01);
  endtask

  task automatic t_pkt();
    mst_pkt_done = 1; @(negedge clk); mst_pkt_done = 0;
    chk("R9 packet flag", irq_status, 8'h10);
    chk("R11 masked no irq", irq, 0);
    mst_status_chg = 1; @(negedge clk); mst_status_chg = 0;
    chk("R9 status flag", irq_status, 8'h90);
    csr_wr(1, 8'h8F);
    chk("R11 enable low bits zero", irq_enable, 8'h80);
    chk("R11 irq on enabled flag", irq, 1);
    csr_wr(0, 8'h80);
    chk("R11 only masked flag left", {irq_status, 7'b0, irq}, {8'h10, 8'h00});
    csr_wr(1, 8'hF0);
    chk("R11 irq via packet flag", irq, 1);
    csr_wr(0, 8'hFF);
    chk("R10 all cleared", {irq_status, 7'b0, irq}, 16'h0000);
    csr_wr(1, 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order_tags();
    t_thresh();
    t_overflow();
    t_rx();
    t_req();
    t_pkt();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule